// File: doc/BRIEF.md
# Subcarrier Response Frame Encoder

This block turns a short tag-to-reader answer into the timed on/off pattern that drives a subcarrier load modulator. A single start strobe loads a payload of up to sixteen bits together with a keystream word and a bit count. The block XORs the payload with the keystream, then plays out a frame of half-bit slots: a fixed eight-slot opening pattern, two slots for every data bit, and a fixed eight-slot closing pattern.

Every slot lasts the same number of clock cycles. During a modulated slot the modulation enable is high and the subcarrier output carries eight square pulses. During an unmodulated slot both outputs stay low. The clock is the carrier clock. With the default divider a slot is 512 cycles, and the subcarrier toggles every 32 cycles. The caller supplies fresh keystream bits for each frame. Typical answers are six bits long for a handshake reply and twelve bits long for a read reply.

Top module: `rsp_frame_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, `busy_o`, `mod_en_o`, `sub_out_o` and `done_o` are low.
- R2: A start strobe seen while idle is accepted. `busy_o` is high from the next cycle on, and the coded word is `payload_i ^ keystream_i`, of which only the low `nbits_i` bits are sent.
- R3: A frame opens with eight slots whose modulation values are, in time order, 0,0,0,1,1,1,0,1 (0x1D read most significant bit first).
- R4: Data bits go out least significant bit first. A coded 1 is an unmodulated slot followed by a modulated slot, and a coded 0 is a modulated slot followed by an unmodulated slot.
- R5: A frame closes with eight slots whose modulation values are, in time order, 1,0,1,1,1,0,0,0 (0xB8 read most significant bit first).
- R6: Each slot lasts 16·2^SUB_SHIFT cycles. In a modulated slot `sub_out_o` is high for the first 2^SUB_SHIFT cycles, then low for as long, and repeats this for eight pulses. In an unmodulated slot `sub_out_o` stays low, and `sub_out_o` is never high while `mod_en_o` is low.
- R7: A bit count of 0 gives a frame of only the opening and closing patterns. A count above MAX_BITS is treated as MAX_BITS.
- R8: A start strobe while `busy_o` is high is ignored. The frame in progress goes on unchanged.
- R9: `done_o` is a one-cycle pulse in the cycle right after the last closing slot, and `busy_o` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one frame |
| payload_i | input | MAX_BITS | Response word, bit 0 sent first |
| keystream_i | input | MAX_BITS | Scrambling bits XORed onto the payload |
| nbits_i | input | $clog2(MAX_BITS+1) | Number of payload bits to send |
| mod_en_o | output | 1 | High during a modulated slot |
| sub_out_o | output | 1 | Subcarrier pulse train |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest situation to reach from the ports is a start strobe that arrives in the middle of a frame. If the block wrongly took it, the effect would only show in later slots, as a reloaded or restarted bit stream. The stimulus raises a strobe with a different payload, keystream and count partway through a twelve-bit frame. The scoreboard then compares every cycle of the remaining slots with the original frame. The clamp on oversized bit counts and the empty-payload frame are reached by driving counts of 20 and 0.

// File: rtl/rsp_enc_pkg.sv
package rsp_enc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SOF  = 2'd1,
        PH_DATA = 2'd2,
        PH_EOF  = 2'd3
    } phase_e;

    // Opening and closing slot patterns, played most significant bit first
    localparam logic [7:0] OPEN_PAT  = 8'h1D;
    localparam logic [7:0] CLOSE_PAT = 8'hB8;
    localparam int unsigned MARK_SLOTS = 8;
endpackage

// File: rtl/rsp_slot_timer.sv
module rsp_slot_timer #(
    parameter int unsigned SUB_SHIFT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic slot_end,
    output logic sub_phase
);
    localparam int unsigned SLOT_CYC = 16 << SUB_SHIFT;
    localparam int unsigned CNT_W    = $clog2(SLOT_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.cnt = '0;
        end else if (run) begin
            tmr_d.cnt = (tmr_q.cnt == LAST) ? '0 : tmr_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign slot_end  = run && (tmr_q.cnt == LAST);
    // High in the first half of each subcarrier period
    assign sub_phase = ~tmr_q.cnt[SUB_SHIFT];

    // The counter only leaves zero while a frame runs
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart && tmr_q.cnt == '0) |=> (tmr_q.cnt == '0));
endmodule

// File: rtl/rsp_frame_seq.sv
module rsp_frame_seq
    import rsp_enc_pkg::*;
#(
    parameter int unsigned MAX_BITS = 16,
    parameter int unsigned NB_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [MAX_BITS-1:0] payload,
    input  logic [MAX_BITS-1:0] keystream,
    input  logic [NB_W-1:0]     nbits,
    input  logic                slot_end,
    output logic                busy,
    output logic                slot_bit,
    output logic                done
);
    localparam int unsigned IDX_W = NB_W + 1;
    localparam logic [IDX_W-1:0] MARK_LAST = IDX_W'(MARK_SLOTS - 1);
    localparam logic [NB_W-1:0]  NB_MAX    = NB_W'(MAX_BITS);

    typedef struct packed {
        phase_e              phase;
        logic [IDX_W-1:0]    idx;
        logic [MAX_BITS-1:0] shreg;
        logic [NB_W-1:0]     nb;
        logic                done;
    } seq_s;

    seq_s seq_d, seq_q;
    logic [IDX_W-1:0] idx_inc;
    logic             data_last;

    assign idx_inc   = seq_q.idx + IDX_W'(1);
    assign data_last = (idx_inc == {seq_q.nb, 1'b0});

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start) begin
                    seq_d.phase = PH_SOF;
                    seq_d.idx   = '0;
                    seq_d.shreg = payload ^ keystream;
                    seq_d.nb    = (nbits > NB_MAX) ? NB_MAX : nbits;
                end
            end
            PH_SOF: begin
                if (slot_end) begin
                    if (seq_q.idx == MARK_LAST) begin
                        seq_d.idx   = '0;
                        seq_d.phase = (seq_q.nb == '0) ? PH_EOF : PH_DATA;
                    end else begin
                        seq_d.idx = idx_inc;
                    end
                end
            end
            PH_DATA: begin
                if (slot_end) begin
                    if (seq_q.idx[0]) seq_d.shreg = seq_q.shreg >> 1;
                    if (data_last) begin
                        seq_d.idx   = '0;
                        seq_d.phase = PH_EOF;
                    end else begin
                        seq_d.idx = idx_inc;
                    end
                end
            end
            PH_EOF: begin
                if (slot_end) begin
                    if (seq_q.idx == MARK_LAST) begin
                        seq_d.idx   = '0;
                        seq_d.phase = PH_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.idx = idx_inc;
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        unique case (seq_q.phase)
            PH_SOF:  slot_bit = OPEN_PAT[3'd7 - seq_q.idx[2:0]];
            PH_DATA: slot_bit = seq_q.idx[0] ? seq_q.shreg[0] : ~seq_q.shreg[0];
            PH_EOF:  slot_bit = CLOSE_PAT[3'd7 - seq_q.idx[2:0]];
            default: slot_bit = 1'b0;
        endcase
    end

    assign busy = (seq_q.phase != PH_IDLE);
    assign done = seq_q.done;

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !slot_end) |=> ($stable(seq_q.shreg) && $stable(seq_q.idx)
                                          && $stable(seq_q.nb)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    p_idle_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !slot_bit);
endmodule

// File: rtl/rsp_frame_encoder.sv
module rsp_frame_encoder
    import rsp_enc_pkg::*;
#(
    parameter int unsigned MAX_BITS  = 16,
    parameter int unsigned SUB_SHIFT = 5,
    parameter int unsigned NB_W      = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] payload_i,
    input  logic [MAX_BITS-1:0] keystream_i,
    input  logic [NB_W-1:0]     nbits_i,
    output logic                mod_en_o,
    output logic                sub_out_o,
    output logic                busy_o,
    output logic                done_o
);
    logic busy, slot_bit, slot_end, sub_phase, accept;

    assign accept = start_i && !busy;

    rsp_slot_timer #(
        .SUB_SHIFT (SUB_SHIFT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .restart   (accept),
        .slot_end  (slot_end),
        .sub_phase (sub_phase)
    );

    rsp_frame_seq #(
        .MAX_BITS (MAX_BITS),
        .NB_W     (NB_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .payload   (payload_i),
        .keystream (keystream_i),
        .nbits     (nbits_i),
        .slot_end  (slot_end),
        .busy      (busy),
        .slot_bit  (slot_bit),
        .done      (done_o)
    );

    assign busy_o    = busy;
    assign mod_en_o  = busy && slot_bit;
    assign sub_out_o = mod_en_o && sub_phase;

    p_sub_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sub_out_o |-> mod_en_o);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mod_en_o && !sub_out_o));
    p_level_in_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !slot_end) |=> $stable(mod_en_o));
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);
endmodule

// File: tb/rsp_frame_encoder_tb.sv
module rsp_frame_encoder_tb;
    localparam int unsigned MAXB  = 16;
    localparam int unsigned SHIFT = 1;
    localparam int unsigned SLOT  = 16 << SHIFT;
    localparam int unsigned NBW   = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [MAXB-1:0] payload = '0, keystream = '0;
    logic [NBW-1:0] nbits = '0;
    logic mod_en, sub_out, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct { bit b; int req; } slot_t;
    slot_t expq[$];

    always #10 clk = ~clk;

    rsp_frame_encoder #(.MAX_BITS(MAXB), .SUB_SHIFT(SHIFT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .payload_i(payload),
        .keystream_i(keystream), .nbits_i(nbits), .mod_en_o(mod_en),
        .sub_out_o(sub_out), .busy_o(busy), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: computes the expected slot list and pushes it before starting
    task automatic send(input logic [MAXB-1:0] p, input logic [MAXB-1:0] k,
                        input int n, input bit poke);
        logic [MAXB-1:0] v;
        int eff;
        bit open_p[8]  = '{0,0,0,1,1,1,0,1};   // R3
        bit close_p[8] = '{1,0,1,1,1,0,0,0};   // R5
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
        v = p ^ k;                               // R2
        eff = (n > MAXB) ? MAXB : n;             // R7
        foreach (open_p[i]) expq.push_back('{open_p[i], 3});
        for (int i = 0; i < eff; i++) begin      // R4: LSB first, 1 -> 0,1
            expq.push_back('{~v[i], 4});
            expq.push_back('{v[i], 4});
        end
        foreach (close_p[i]) expq.push_back('{close_p[i], 5});
        payload = p; keystream = k; nbits = NBW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        if (poke) begin                          // R8: strobe mid-frame
            repeat (9 * SLOT + 5) @(negedge clk);
            payload = ~p; keystream = 16'h5555; nbits = NBW'(3); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R8", "busy kept", busy, 1);
        end
    endtask

    // Monitor: compares every cycle of every slot with the queue
    int  cyc = 0;
    bit  prev_busy = 1'b0, prev_done = 1'b0, bad = 1'b0;
    slot_t cur;
    int  act_m, act_s, exp_s;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy) begin
                if (cyc == 0) begin
                    bad = 1'b0;
                    if (expq.size() == 0) begin
                        cur = '{0, 3};
                        check(1'b0, "R9", "slot beyond frame end", 1, 0);
                    end else begin
                        cur = expq.pop_front();
                    end
                end
                exp_s = cur.b & ~((cyc >> SHIFT) & 1);   // R6 pulse shape
                if (!bad && (mod_en != cur.b || sub_out != exp_s[0])) begin
                    bad = 1'b1; act_m = mod_en; act_s = sub_out;
                end
                if (cyc == SLOT - 1) begin
                    check(!bad, $sformatf("R%0d/R6", cur.req), "slot mod_en,sub_out",
                          act_m * 2 + act_s, cur.b * 2 + cur.b);
                    cyc = 0;
                end else begin
                    cyc++;
                end
                check(done == 1'b0, "R9", "done while busy", done, 0);
            end else begin
                if (prev_busy) begin
                    check(expq.size() == 0 && cyc == 0, "R9", "frame length",
                          expq.size(), 0);
                    check(done == 1'b1, "R9", "done pulse", done, 1);
                end else if (prev_done) begin
                    check(done == 1'b0, "R9", "done one cycle", done, 0);
                end
                check(mod_en == 1'b0 && sub_out == 1'b0, "R1", "idle outputs",
                      mod_en * 2 + sub_out, 0);
                cyc = 0;
            end
            prev_busy = busy;
            prev_done = done;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1", "busy in reset", busy, 0);
        check(mod_en == 0, "R1", "mod_en in reset", mod_en, 0);
        check(sub_out == 0, "R1", "sub_out in reset", sub_out, 0);
        check(done == 0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        send(16'h0015, 16'h0026, 6, 1'b0);      // handshake-size answer
        send(16'h0ABC, 16'h05A3, 12, 1'b1);     // read-size answer, R8 poke
        send(16'h1234, 16'hFFFF, 0, 1'b0);      // R7: empty payload
        send(16'hF0F3, 16'h1234, 20, 1'b0);     // R7: clamp to MAX_BITS
        send(16'hFFFE, 16'h0000, 1, 1'b0);      // R2: upper bits ignored
        send(16'hFFFF, 16'h0000, 16, 1'b0);     // all ones
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R9", "queue drained", expq.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule